// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block forms the byte a host sees when it reads the memory while an embedded program or erase operation is under way. A sequencer elsewhere launches the operation when the final write of a program or erase command sequence is accepted. The controller then reports completion, time-limit failure, erase suspension and the end of the erase start window. From these inputs the block builds a status byte with four meaningful bits. Bit 7 is the polling bit. Bit 6 is the toggle bit. Bit 5 is the error bit. Bit 3 is the erase-timer bit. Every other bit reads as zero. When no operation is active, the same read path returns the array data.

A read access is the rising edge of a read strobe. The byte returned by a read is captured at that edge and is held on the output until the next read. The toggle bit flips once per status read, so a host can poll until two reads agree. A program aimed at a protected block is dropped. An erase whose every target is protected reports busy for a fixed number of clock cycles and then falls back to array data.

Top module: `pe_status_gen`

## Requirements
- R1: After reset, `rd_data` is 8'h00 and `rd_is_status` is 0. The first read after reset returns `array_data`.
- R2: During an accepted program, bit 7 of a status read is the complement of bit 7 of the byte that was latched at launch.
- R3: During an accepted erase, and during the dwell for a fully protected erase, bit 7 of a status read is 0.
- R4: The first status read after an accepted launch has bit 6 = 0. Each later status read inverts bit 6. Clock cycles with no read leave bit 6 unchanged.
- R5: A `ctl_timeout` pulse during a program or erase sets bit 5 to 1 in every later status read. The bit stays set even after `ctl_done`, until `reset_cmd`.
- R6: During an erase, bit 3 equals `ctl_window_done` (0 while the start window runs, 1 once it has expired). Bit 3 is 0 during a program and during the protected-erase dwell.
- R7: Bits 4, 2, 1 and 0 of every status read are 0.
- R8: After `ctl_done` ends a program or erase with no failure, reads return `array_data` and `rd_is_status` is 0.
- R9: A `launch_prog` with `tgt_protected` = 1 is ignored. The next read returns `array_data`.
- R10: A `launch_erase` with `tgt_protected` = 1 produces status reads for read edges 1 to DWELL_CYCLES clock edges after the launch edge. After that, reads return `array_data`.
- R11: While `ctl_suspend` is 1 during an erase, reads return `array_data` and bit 6 does not advance. After resume, the toggle sequence continues from where it stopped.
- R12: `rd_data` and `rd_is_status` change only at the clock edge where `rd_stb` rises.
- R13: `reset_cmd` ends any operation, or a failure report, and later reads return `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_prog | input | 1 | Pulse: program command fully accepted |
| launch_erase | input | 1 | Pulse: erase command fully accepted |
| tgt_protected | input | 1 | Target block (or all erase targets) protected, sampled with a launch |
| prog_byte | input | 8 | Byte being programmed, sampled with `launch_prog` |
| ctl_done | input | 1 | Pulse: controller finished the operation |
| ctl_timeout | input | 1 | Pulse: controller exceeded its time limit |
| ctl_suspend | input | 1 | Level: erase suspend in effect |
| ctl_window_done | input | 1 | Level: erase start window has expired |
| reset_cmd | input | 1 | Pulse: reset instruction |
| rd_stb | input | 1 | Read strobe; a rising edge is one read access |
| array_data | input | 8 | Normal array read data |
| rd_data | output | 8 | Byte returned by the last read |
| rd_is_status | output | 1 | Last read returned the status byte |

## Verification
The hardest case to reach is the edge of the protected-erase dwell, where a single clock decides between status and array data. The bench launches a protected erase and places the read's rising edge at every offset from 1 to DWELL_CYCLES+2 clocks after the launch edge. It clears the block with a reset command between attempts. The toggle freeze under suspend is reached by interleaving reads with suspend toggling, so the bench can check that the sequence resumes rather than restarts. All 256 programmed bytes are swept for the polling bit, both protected and unprotected.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_DWELL = 3'd3,
    M_FAIL  = 3'd4
  } pe_mode_t;

  // Positions are read by host polling software, so they are fixed.
  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int ERR_POS  = 5;
  localparam int TMR_POS  = 3;

  function automatic logic [7:0] pack_status(input logic poll, input logic tog,
                                             input logic err, input logic tmr);
    logic [7:0] s;
    s = 8'h00;
    s[POLL_POS] = poll;
    s[TOG_POS]  = tog;
    s[ERR_POS]  = err;
    s[TMR_POS]  = tmr;
    return s;
  endfunction

endpackage

// File: rtl/pe_status_seq.sv
module pe_status_seq
  import pe_status_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DWELL_CYCLES = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_prog,
  input  logic              launch_erase,
  input  logic              tgt_protected,
  input  logic [DATA_W-1:0] prog_byte,
  input  logic              ctl_done,
  input  logic              ctl_timeout,
  input  logic              ctl_suspend,
  input  logic              ctl_window_done,
  input  logic              reset_cmd,
  output pe_mode_t          mode,
  output logic              poll_bit,
  output logic              tmr_bit,
  output logic              status_sel,
  output logic              tog_clr
);
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] dwell_cnt;
  logic             op_erase;
  logic             take_erase, take_prog;

  assign take_erase = (mode == M_IDLE) && launch_erase && !reset_cmd;
  assign take_prog  = (mode == M_IDLE) && launch_prog && !launch_erase &&
                      !tgt_protected && !reset_cmd;
  assign tog_clr    = take_erase || take_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= M_IDLE;
      dwell_cnt <= '0;
      op_erase  <= 1'b0;
      poll_bit  <= 1'b0;
    end else if (reset_cmd) begin
      mode <= M_IDLE;
    end else begin
      unique case (mode)
        M_IDLE: begin
          if (take_erase) begin
            op_erase <= 1'b1;
            poll_bit <= 1'b0;
            if (tgt_protected) begin
              mode      <= M_DWELL;
              dwell_cnt <= CNT_LOAD;
            end else begin
              mode <= M_ERASE;
            end
          end else if (take_prog) begin
            op_erase <= 1'b0;
            poll_bit <= ~prog_byte[DATA_W-1];
            mode     <= M_PROG;
          end
        end
        M_PROG, M_ERASE: begin
          if (ctl_timeout)   mode <= M_FAIL;
          else if (ctl_done) mode <= M_IDLE;
        end
        M_DWELL: begin
          if (dwell_cnt == '0) mode <= M_IDLE;
          else                 dwell_cnt <= dwell_cnt - 1'b1;
        end
        M_FAIL: mode <= M_FAIL;
        default: mode <= M_IDLE;
      endcase
    end
  end

  assign tmr_bit    = op_erase && (mode != M_DWELL) && ctl_window_done;
  assign status_sel = (mode == M_PROG) || (mode == M_DWELL) || (mode == M_FAIL) ||
                      ((mode == M_ERASE) && !ctl_suspend);

  // R9: protected program launch leaves the block idle
  p_prot_prog_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_IDLE && launch_prog && !launch_erase && tgt_protected && !reset_cmd)
    |=> (mode == M_IDLE));

  // R5: a failure report persists until the reset command
  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_FAIL && !reset_cmd) |=> (mode == M_FAIL));

  // R10: dwell lasts while the counter is non-zero
  p_dwell_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DWELL && dwell_cnt != '0 && !reset_cmd) |=> (mode == M_DWELL));

  // R13: reset command always returns to idle
  p_reset_cmd_r13: assert property (@(posedge clk) disable iff (rst)
    reset_cmd |=> (mode == M_IDLE));

endmodule

// File: rtl/pe_status_toggle.sv
module pe_status_toggle (
  input  logic clk,
  input  logic rst,
  input  logic rd_stb,
  input  logic active,
  input  logic clr,
  output logic rd_rise,
  output logic tog
);
  logic rd_q;

  assign rd_rise = rd_stb && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (clr)                  tog <= 1'b0;
      else if (rd_rise && active) tog <= ~tog;
    end
  end

  // R4: no read access, no toggle movement
  p_tog_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd_rise && !clr) |=> $stable(tog));

  // R11: suspended (inactive) reads do not move the toggle
  p_tog_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (!active && !clr) |=> $stable(tog));

endmodule

// File: rtl/pe_status_out.sv
module pe_status_out
  import pe_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_rise,
  input  logic              status_sel,
  input  logic              poll_bit,
  input  logic              tog,
  input  logic              err_bit,
  input  logic              tmr_bit,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_is_status
);
  logic [DATA_W-1:0] stat_word;

  assign stat_word = DATA_W'(pack_status(poll_bit, tog, err_bit, tmr_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      rd_is_status <= 1'b0;
    end else if (rd_rise) begin
      rd_data      <= status_sel ? stat_word : array_data;
      rd_is_status <= status_sel;
    end
  end

  // R7: reserved positions read as zero in a status byte
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && status_sel) |=> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000));

  // R12: output moves only on a read access
  p_hold_between_reads_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_rise |=> ($stable(rd_data) && $stable(rd_is_status)));

  // R8: array reads carry the array byte
  p_array_path_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && !status_sel) |=> (rd_data == $past(array_data) && !rd_is_status));

endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DWELL_CYCLES = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_prog,
  input  logic              launch_erase,
  input  logic              tgt_protected,
  input  logic [DATA_W-1:0] prog_byte,
  input  logic              ctl_done,
  input  logic              ctl_timeout,
  input  logic              ctl_suspend,
  input  logic              ctl_window_done,
  input  logic              reset_cmd,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_is_status
);
  pe_mode_t mode;
  logic     poll_bit, tmr_bit, status_sel, tog_clr, rd_rise, tog, err_bit;

  pe_status_seq #(.DATA_W(DATA_W), .DWELL_CYCLES(DWELL_CYCLES)) seq_i (
    .clk(clk), .rst(rst),
    .launch_prog(launch_prog), .launch_erase(launch_erase),
    .tgt_protected(tgt_protected), .prog_byte(prog_byte),
    .ctl_done(ctl_done), .ctl_timeout(ctl_timeout),
    .ctl_suspend(ctl_suspend), .ctl_window_done(ctl_window_done),
    .reset_cmd(reset_cmd), .mode(mode), .poll_bit(poll_bit),
    .tmr_bit(tmr_bit), .status_sel(status_sel), .tog_clr(tog_clr)
  );

  pe_status_toggle tog_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .active(status_sel),
    .clr(tog_clr), .rd_rise(rd_rise), .tog(tog)
  );

  assign err_bit = (mode == M_FAIL);

  pe_status_out #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .rd_rise(rd_rise), .status_sel(status_sel),
    .poll_bit(poll_bit), .tog(tog), .err_bit(err_bit), .tmr_bit(tmr_bit),
    .array_data(array_data), .rd_data(rd_data), .rd_is_status(rd_is_status)
  );

endmodule

// File: tb/pe_status_gen_tb.sv
module pe_status_gen_tb_top;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic launch_prog = 0, launch_erase = 0, tgt_protected = 0;
  logic [7:0] prog_byte = 0;
  logic ctl_done = 0, ctl_timeout = 0, ctl_suspend = 0, ctl_window_done = 0;
  logic reset_cmd = 0, rd_stb = 0;
  logic [7:0] array_data = 8'hA5;
  logic [7:0] rd_data;
  logic rd_is_status;

  int n_chk = 0, n_fail = 0;
  logic [7:0] got;
  logic got_st;

  always #4 clk = ~clk;

  pe_status_gen #(.DATA_W(8), .DWELL_CYCLES(DW)) dut_i (
    .clk(clk), .rst(rst), .launch_prog(launch_prog), .launch_erase(launch_erase),
    .tgt_protected(tgt_protected), .prog_byte(prog_byte), .ctl_done(ctl_done),
    .ctl_timeout(ctl_timeout), .ctl_suspend(ctl_suspend),
    .ctl_window_done(ctl_window_done), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
    .array_data(array_data), .rd_data(rd_data), .rd_is_status(rd_is_status)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic p, input logic t, input logic e, input logic w);
    return {p, t, e, 1'b0, w, 3'b000};
  endfunction

  task automatic do_read();
    rd_stb = 1;
    @(negedge clk);
    got = rd_data;
    got_st = rd_is_status;
    rd_stb = 0;
    @(negedge clk);
  endtask

  task automatic pulse_reset_cmd();
    reset_cmd = 1; @(negedge clk); reset_cmd = 0;
  endtask
  task automatic pulse_done();
    ctl_done = 1; @(negedge clk); ctl_done = 0;
  endtask
  task automatic pulse_timeout();
    ctl_timeout = 1; @(negedge clk); ctl_timeout = 0;
  endtask
  task automatic go_prog(input logic [7:0] b, input logic prot);
    prog_byte = b; tgt_protected = prot; launch_prog = 1;
    @(negedge clk); launch_prog = 0; tgt_protected = 0;
  endtask
  task automatic go_erase(input logic prot);
    tgt_protected = prot; launch_erase = 1;
    @(negedge clk); launch_erase = 0; tgt_protected = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 is_status", {7'b0, rd_is_status}, 8'h00);
    do_read();
    check("R1 first read", got, 8'hA5);

    // R2 R8 R9: sweep of every programmed byte
    for (int b = 0; b < 256; b++) begin
      array_data = 8'(b ^ 8'h3C);
      go_prog(8'(b), 1'b1);
      do_read();
      check("R9 protected program ignored", got, 8'(b ^ 8'h3C));
      go_prog(8'(b), 1'b0);
      do_read();
      check("R2 poll bit", got, stat(~b[7], 1'b0, 1'b0, 1'b0));
      check("R7 status flag", {7'b0, got_st}, 8'h01);
      pulse_done();
      do_read();
      check("R8 after done", got, 8'(b ^ 8'h3C));
    end
    array_data = 8'hA5;

    // R3 R4 R6 R12: erase, toggle sequence, window bit
    go_erase(1'b0);
    do_read();
    check("R3 R6 erase window running", got, stat(0, 0, 0, 0));
    repeat (5) @(negedge clk);
    do_read();
    check("R4 second read toggles", got, stat(0, 1, 0, 0));
    array_data = 8'h11;
    repeat (4) @(negedge clk);
    check("R12 held between reads", rd_data, stat(0, 1, 0, 0));
    ctl_window_done = 1;
    @(negedge clk);
    do_read();
    check("R6 window expired", got, stat(0, 0, 0, 1));
    do_read();
    check("R4 fourth read", got, stat(0, 1, 0, 1));

    // R11 suspend
    ctl_suspend = 1;
    @(negedge clk);
    do_read();
    check("R11 suspended read array", got, 8'h11);
    do_read();
    check("R11 suspended read array again", got, 8'h11);
    ctl_suspend = 0;
    @(negedge clk);
    do_read();
    check("R11 toggle resumes", got, stat(0, 0, 0, 1));
    pulse_done();
    do_read();
    check("R8 erase done", got, 8'h11);
    ctl_window_done = 0;

    // R5 failure on program
    go_prog(8'h00, 1'b0);
    pulse_timeout();
    do_read();
    check("R5 error bit", got, stat(1, 0, 1, 0));
    pulse_done();
    do_read();
    check("R5 sticky after done", got, stat(1, 1, 1, 0));
    pulse_reset_cmd();
    do_read();
    check("R13 reset clears failure", got, 8'h11);

    // R5 failure on erase
    go_erase(1'b0);
    pulse_timeout();
    do_read();
    check("R5 erase error bit", got, stat(0, 0, 1, 0));
    pulse_reset_cmd();

    // R13 abort running erase
    go_erase(1'b0);
    do_read();
    check("R13 erase active", {7'b0, got_st}, 8'h01);
    pulse_reset_cmd();
    do_read();
    check("R13 abort to array", got, 8'h11);

    // R10 dwell sweep: read edge d clocks after launch edge
    for (int d = 1; d <= DW + 2; d++) begin
      go_erase(1'b1);
      repeat (d - 1) @(negedge clk);
      do_read();
      if (d <= DW) check("R10 dwell status", got, stat(0, 0, 0, 0));
      else         check("R10 dwell ended", got, 8'h11);
      pulse_reset_cmd();
    end

    // R7 reserved zero under a busy pattern
    ctl_window_done = 1;
    go_erase(1'b0);
    do_read();
    check("R7 reserved bits", got & 8'h17, 8'h00);
    pulse_reset_cmd();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule